// File: doc/BRIEF.md
# Slot-Indexed Distinct-Value Set

This block holds up to `N` distinct data words in registers and offers them through commands that work like a software unordered set. An insert adds a word unless it is already present. It reports whether the word is now in the set, or whether the insert failed because every slot is taken. A remove names a slot and empties it. Naming a slot that is already empty, or one beyond the capacity, is allowed and changes nothing.

Reading the contents works through iterators. An iterator is the index of a storage slot. A get-first command returns the lowest occupied slot. A step command returns the next occupied slot strictly above the iterator it is given. Both commands give the same result: the new iterator, the word held in that slot, and an end flag that rises when no such slot exists. The storage is private and can only be reached through these commands.

The block accepts one command per cycle. Each result appears on the clock edge after the command was taken, together with a strobe. A command sees the effects of every earlier command, including the one in the cycle just before it.

Top module: `slot_set`

## Requirements
- R1: Every cycle with `cmd_valid_i` high produces exactly one response, with `rsp_valid_o` high on the next clock edge and `rsp_op_o` equal to the command's opcode. When no command is given, `rsp_valid_o` stays low. Opcodes: 2'b00 insert, 2'b01 remove, 2'b10 get-first, 2'b11 step.
- R2: An insert of a word that is not present stores it in the lowest-index empty slot. The response has `rsp_ok_o`=1, `rsp_iter_o` = that slot, `rsp_data_o` = the word and `rsp_end_o`=0.
- R3: An insert of a word that is already present changes no storage and never makes a second copy, even when the set is full. The response has `rsp_ok_o`=1 and `rsp_iter_o` = the slot that already holds the word.
- R4: An insert of an absent word while all `N` slots are occupied changes nothing. The response has `rsp_ok_o`=0, `rsp_iter_o`=0 and `rsp_data_o` = the word.
- R5: A remove empties the slot named by `cmd_iter_i`. The response has `rsp_ok_o`=1, `rsp_iter_o` = the given iterator, `rsp_data_o`=0 and `rsp_end_o`=0.
- R6: A remove that names an empty slot, or an index of `N` or more, leaves the set unchanged and still responds as in R5.
- R7: Get-first returns the lowest occupied slot and its word, with `rsp_ok_o`=1 and `rsp_end_o`=0.
- R8: Step returns the lowest occupied slot whose index is strictly greater than `cmd_iter_i`, together with its word.
- R9: When get-first or step finds no occupied slot, the response has `rsp_end_o`=1, `rsp_ok_o`=0, `rsp_iter_o`=0 and `rsp_data_o`=0.
- R10: Reset empties every slot, so the first get-first after reset reports the end of the set.
- R11: A command given in the cycle right after another command sees that earlier command's effect on the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Opcode: insert, remove, get-first, step |
| cmd_data_i | input | W | Word to insert |
| cmd_iter_i | input | IW | Iterator for remove and step |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the command |
| rsp_op_o | output | 2 | Opcode being answered |
| rsp_ok_o | output | 1 | Insert stored or found, remove done, or iterate found a slot |
| rsp_iter_o | output | IW | Resulting iterator |
| rsp_data_o | output | W | Word at the resulting iterator |
| rsp_end_o | output | 1 | Iteration ran past the last occupied slot |

## Verification
Commands arrive back to back, so the state change made by one command and the lookup for the next one fall in the same clock cycle. Two cases matter most. A remove followed at once by an insert must reuse the slot that was just freed. An insert followed at once by a step must already see the new word. The bench provokes these cases in directed pairs and then in a long stream with random gaps, using a small value range so that duplicates and full-set inserts occur often. On every clock it compares all response fields with a behavioural model that applies each command in order.

// File: rtl/uset_pkg.sv
package uset_pkg;
  typedef enum logic [1:0] {
    OP_INS   = 2'b00,
    OP_REM   = 2'b01,
    OP_FIRST = 2'b10,
    OP_NEXT  = 2'b11
  } uset_op_e;
endpackage

// File: rtl/uset_lowest.sv
// Lowest set bit finder.
module uset_lowest #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/uset_match.sv
// Per-slot key compare, gated by occupancy.
module uset_match #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] slots_i,
  input  logic [N-1:0]        valid_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (slots_i[g] == key_i);
  end
endmodule

// File: rtl/uset_window.sv
// Builds the candidate mask for iteration: all slots, or those above the iterator.
module uset_window #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          from_start_i,
  input  logic [IW-1:0] iter_i,
  output logic [N-1:0]  mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_win
    assign mask_o[g] = from_start_i || (32'(g) > 32'(iter_i));
  end
endmodule

// File: rtl/slot_set.sv
module slot_set #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [W-1:0]  cmd_data_i,
  input  logic [IW-1:0] cmd_iter_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_op_o,
  output logic          rsp_ok_o,
  output logic [IW-1:0] rsp_iter_o,
  output logic [W-1:0]  rsp_data_o,
  output logic          rsp_end_o
);
  import uset_pkg::*;

  logic [N-1:0][W-1:0] slots_q;
  logic [N-1:0]        valid_q;

  uset_op_e op;
  assign op = uset_op_e'(cmd_op_i);

  logic [N-1:0]  hit_vec;
  logic          hit_any;
  logic [IW-1:0] hit_idx;
  logic          free_any;
  logic [IW-1:0] free_idx;
  logic [N-1:0]  win_mask;
  logic          scan_any;
  logic [IW-1:0] scan_idx;
  logic          rem_in_range;

  uset_match #(.N(N), .W(W)) u_match (
    .slots_i(slots_q), .valid_i(valid_q), .key_i(cmd_data_i), .hit_o(hit_vec)
  );

  uset_lowest #(.N(N), .IW(IW)) u_hit (
    .vec_i(hit_vec), .found_o(hit_any), .idx_o(hit_idx)
  );

  uset_lowest #(.N(N), .IW(IW)) u_free (
    .vec_i(~valid_q), .found_o(free_any), .idx_o(free_idx)
  );

  uset_window #(.N(N), .IW(IW)) u_win (
    .from_start_i(op == OP_FIRST), .iter_i(cmd_iter_i), .mask_o(win_mask)
  );

  uset_lowest #(.N(N), .IW(IW)) u_scan (
    .vec_i(valid_q & win_mask), .found_o(scan_any), .idx_o(scan_idx)
  );

  assign rem_in_range = 32'(cmd_iter_i) < N;

  // Response next-state
  logic          ok_d;
  logic [IW-1:0] iter_d;
  logic [W-1:0]  data_d;
  logic          end_d;

  always_comb begin
    ok_d   = 1'b0;
    iter_d = '0;
    data_d = '0;
    end_d  = 1'b0;
    unique case (op)
      OP_INS: begin
        data_d = cmd_data_i;
        if (hit_any) begin
          ok_d   = 1'b1;
          iter_d = hit_idx;
        end else if (free_any) begin
          ok_d   = 1'b1;
          iter_d = free_idx;
        end
      end
      OP_REM: begin
        ok_d   = 1'b1;
        iter_d = cmd_iter_i;
      end
      default: begin
        if (scan_any) begin
          ok_d   = 1'b1;
          iter_d = scan_idx;
          data_d = slots_q[scan_idx];
        end else begin
          end_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (cmd_valid_i) begin
      if (op == OP_INS && !hit_any && free_any) begin
        valid_q[free_idx] <= 1'b1;
      end else if (op == OP_REM && rem_in_range) begin
        valid_q[cmd_iter_i] <= 1'b0;
      end
    end
  end

  // Data storage needs no reset; occupancy gates every read.
  always_ff @(posedge clk_i) begin
    if (cmd_valid_i && op == OP_INS && !hit_any && free_any) begin
      slots_q[free_idx] <= cmd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_op_o    <= '0;
      rsp_ok_o    <= 1'b0;
      rsp_iter_o  <= '0;
      rsp_data_o  <= '0;
      rsp_end_o   <= 1'b0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        rsp_op_o   <= cmd_op_i;
        rsp_ok_o   <= ok_d;
        rsp_iter_o <= iter_d;
        rsp_data_o <= data_d;
        rsp_end_o  <= end_d;
      end
    end
  end
endmodule

// File: rtl/uset_chk.sv
module uset_chk #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic [IW-1:0] cmd_iter_i,
  input logic          rsp_valid_o,
  input logic [1:0]    rsp_op_o,
  input logic          rsp_ok_o,
  input logic [IW-1:0] rsp_iter_o,
  input logic [W-1:0]  rsp_data_o,
  input logic          rsp_end_o,
  input logic [N-1:0]  valid_q
);
  // R1
  rsp_follows_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  // R1
  no_idle_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  // R4
  fail_only_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_o == 2'b00 && !rsp_ok_o) |-> $past(&valid_q));

  // R5
  remove_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_o == 2'b01) |-> (rsp_ok_o && !rsp_end_o));

  // R7
  iter_lands_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_o[1] && !rsp_end_o) |-> valid_q[rsp_iter_o]);

  // R8
  step_moves_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b11) |=> (rsp_end_o || rsp_iter_o > $past(cmd_iter_i)));

  // R9
  end_zeroed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_end_o) |-> (rsp_data_o == '0 && rsp_iter_o == '0 && !rsp_ok_o));
endmodule

bind slot_set uset_chk #(.N(N), .W(W), .IW(IW)) u_chk (.*);

// File: tb/slot_set_bench.sv
module slot_set_bench;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [1:0]    cmd_op_i = '0;
  logic [W-1:0]  cmd_data_i = '0;
  logic [IW-1:0] cmd_iter_i = '0;
  logic          rsp_valid_o;
  logic [1:0]    rsp_op_o;
  logic          rsp_ok_o;
  logic [IW-1:0] rsp_iter_o;
  logic [W-1:0]  rsp_data_o;
  logic          rsp_end_o;

  always #5 clk_i = ~clk_i;

  slot_set #(.N(N), .W(W), .IW(IW)) u_slot_set (.*);

  int compared = 0;
  int mismatched = 0;

  // Behavioural model
  logic [W-1:0] m_data [N];
  bit           m_used [N];

  bit           e_v = 0;
  logic [1:0]   e_op;
  bit           e_ok, e_end;
  int           e_iter;
  logic [W-1:0] e_data;
  string        e_tag = "R10";

  task automatic compare();
    compared++;
    if (rsp_valid_o !== e_v) begin
      mismatched++;
      $display("FAIL %s valid act=%0b exp=%0b", e_tag, rsp_valid_o, e_v);
    end else if (e_v && (rsp_op_o !== e_op || rsp_ok_o !== e_ok || rsp_end_o !== e_end ||
                         rsp_iter_o !== IW'(e_iter) || rsp_data_o !== e_data)) begin
      mismatched++;
      $display("FAIL %s act op=%0d ok=%0b end=%0b it=%0d d=%h exp op=%0d ok=%0b end=%0b it=%0d d=%h",
               e_tag, rsp_op_o, rsp_ok_o, rsp_end_o, rsp_iter_o, rsp_data_o,
               e_op, e_ok, e_end, e_iter, e_data);
    end
  endtask

  // One clock: check previous response, then drive the next command (or idle).
  task automatic step(bit v, int op, logic [W-1:0] d, int it, string tag);
    @(negedge clk_i);
    compare();
    cmd_valid_i = v;
    cmd_op_i    = 2'(op);
    cmd_data_i  = d;
    cmd_iter_i  = IW'(it);
    e_v = v; e_tag = tag; e_op = 2'(op);
    e_ok = 0; e_end = 0; e_iter = 0; e_data = '0;
    if (v) begin
      case (op)
        0: begin
          int hit, fr;
          hit = -1; fr = -1;
          e_data = d;
          for (int j = 0; j < N; j++) if (m_used[j] && m_data[j] == d && hit < 0) hit = j;
          for (int j = 0; j < N; j++) if (!m_used[j] && fr < 0) fr = j;
          if (hit >= 0) begin e_ok = 1; e_iter = hit; end
          else if (fr >= 0) begin e_ok = 1; e_iter = fr; m_used[fr] = 1; m_data[fr] = d; end
        end
        1: begin
          e_ok = 1; e_iter = it;
          if (it < N) m_used[it] = 0;
        end
        default: begin
          int f;
          f = -1;
          for (int j = (op == 2) ? 0 : it + 1; j < N; j++) if (m_used[j] && f < 0) f = j;
          if (f >= 0) begin e_ok = 1; e_iter = f; e_data = m_data[f]; end
          else e_end = 1;
        end
      endcase
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int j = 0; j < N; j++) begin m_used[j] = 0; m_data[j] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R10");        // reset state: no response
    step(1, 2, 0, 0, "R10");        // get-first on empty set -> end
    step(1, 3, 0, 0, "R9");         // step on empty set -> end
    // R2 fill lowest free slots, back to back
    for (int k = 0; k < 5; k++) step(1, 0, 16'h1000 + 16'(k), 0, "R2");
    step(1, 0, 16'h1002, 0, "R3");  // duplicate insert
    step(1, 2, 0, 0, "R7");
    for (int k = 0; k < 5; k++) step(1, 3, 0, k, "R8");
    step(1, 1, 0, 1, "R5");         // remove slot 1
    step(1, 0, 16'h2222, 0, "R11"); // reuses freed slot 1 at once
    step(1, 3, 0, 0, "R11");        // sees new word in slot 1
    step(1, 1, 0, 3, "R5");
    step(1, 1, 0, 3, "R6");         // already empty
    step(1, 1, 0, 7, "R6");         // never used
    step(1, 3, 0, 2, "R8");         // skips empty slot 3
    for (int k = 0; k < 4; k++) step(1, 0, 16'h3000 + 16'(k), 0, "R2");
    step(1, 0, 16'h4444, 0, "R4");  // full
    step(1, 0, 16'h3001, 0, "R3");  // present while full
    step(1, 3, 0, 7, "R9");         // past last slot
    step(1, 2, 0, 0, "R7");
    step(0, 0, 0, 0, "R1");
    // Mixed stream with random gaps; narrow values force duplicates and fulls
    for (int k = 0; k < 2000; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) step(0, 0, 0, 0, "R1");
      else step(1, int'($urandom_range(0, 3)), 16'($urandom_range(0, 11)),
                int'($urandom_range(0, 7)), "R11");
    end
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    finish_run();
  end
endmodule